// File: doc/BRIEF.md
# Sync Polarity Normaliser

This block takes the raw horizontal and vertical sync inputs of a display timing path and hands later stages sync pulses that are always active-high. Each channel first passes its input through a two-stage synchroniser. It then measures how many clocks the signal spends high and how many it spends low between two rising edges. At the end of each such period it decides whether the input is active-low. An input is treated as active-low when its high time exceeds its low time. In that case the channel inverts the synchronised input to form its output.

The block also reports whether each channel's decision can be trusted. A channel counts consecutive periods on which its decision did not change. It raises its settled flag only once that run reaches a per-channel limit, which defaults to 61 lines for horizontal and 5 frames for vertical. The run is restarted by any of three events: a change of decision, a mode-change pulse from the period measurement logic, or a channel that has seen no rising edge for an idle window. The default idle window is 1.2 ms worth of clocks at 10 MHz for horizontal.

Top module: `sync_polarity_norm`

## Requirements
- R1: Each corrected output equals its sync input delayed by two clocks, inverted when that channel's inversion flag is 1 and passed straight when it is 0.
- R2: On every rising edge of the synchronised input, except the first after reset or a restart, the channel compares the clocks spent high with the clocks spent low in the period that has just ended. The inversion flag becomes 1 if the high count is larger and 0 otherwise, so a tie gives 0. The new flag is visible three clocks after the input rises.
- R3: The horizontal settled flag rises after H_SETTLE consecutive agreeing decisions. This is three clocks after the (H_SETTLE+1)-th rising edge that follows reset or a restart.
- R4: The vertical settled flag behaves the same way with V_SETTLE decisions.
- R5: A decision that differs from the current flag updates the flag and clears settled in the same clock. The run count then restarts at one.
- R6: A one-clock pulse on mode_chg clears both settled flags at the next clock. The next rising edge on each channel only re-arms measurement and is not counted as a decision.
- R7: If no horizontal rising edge is seen for H_IDLE clocks after the last decision update, h_settled falls. h_inv keeps its value.
- R8: The vertical channel does the same with V_IDLE.
- R9: After reset, both flags and both settled outputs are 0, and with low inputs both corrected outputs are 0.
- R10: Activity on the horizontal input changes neither v_inv nor v_settled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_in | input | 1 | Raw horizontal sync, either polarity |
| vsync_in | input | 1 | Raw vertical sync, either polarity |
| mode_chg | input | 1 | One-clock pulse from the period logic when the timing mode changes |
| hsync_out | output | 1 | Active-high horizontal sync |
| vsync_out | output | 1 | Active-high vertical sync |
| h_inv | output | 1 | 1 when the horizontal input is judged active-low |
| v_inv | output | 1 | 1 when the vertical input is judged active-low |
| h_settled | output | 1 | Horizontal decision stable for H_SETTLE lines |
| v_settled | output | 1 | Vertical decision stable for V_SETTLE frames |

## Verification
- Corrected outputs are due two clocks after the bench drives an input level.
- Flag and settled updates are due three clocks after the driven rising edge, one clock for each synchroniser stage and one for the decision register.
- An idle timeout clears settled H_IDLE+3 clocks after the last rising edge, and a mode pulse clears it one clock later.
- The driver stamps each expected value with the absolute cycle on which it falls due, and the monitor compares it only on that cycle, at the falling clock edge. The settle and idle boundaries are probed on both sides: one cycle or one edge early, and exactly on time.

// File: rtl/sp_pkg.sv
package sp_pkg;

  // Input is active-low when it spends more clocks high than low.
  function automatic logic high_dominant(input logic [31:0] hi_cnt,
                                         input logic [31:0] lo_cnt);
    return hi_cnt > lo_cnt;
  endfunction

  // Length of the agreeing run after one more decision.
  function automatic int next_run(input int cur, input int limit, input logic agree);
    if (!agree) return 1;
    if (cur >= limit) return limit;
    return cur + 1;
  endfunction

endpackage

// File: rtl/sp_sync.sv
module sp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  if (STAGES > 1) begin : g_multi
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '0;
      else        pipe <= {pipe[STAGES-2:0], d};
    end
  end else begin : g_single
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '0;
      else        pipe <= d;
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/sp_duty_cmp.sv
module sp_duty_cmp #(
  parameter int CW = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic restart,
  output logic rise_ev,
  output logic dec_ev,
  output logic dec_neg
);
  logic          lvl_d;
  logic          armed_q;
  logic [CW-1:0] hi_q;
  logic [CW-1:0] lo_q;

  assign rise_ev = lvl & ~lvl_d;
  assign dec_ev  = rise_ev & armed_q & ~restart;
  assign dec_neg = sp_pkg::high_dominant(32'(hi_q), 32'(lo_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_d   <= 1'b0;
      armed_q <= 1'b0;
      hi_q    <= '0;
      lo_q    <= '0;
    end else begin
      lvl_d <= lvl;
      if (rise_ev) begin
        hi_q <= CW'(1);
        lo_q <= '0;
      end else if (lvl) begin
        if (hi_q != '1) hi_q <= hi_q + 1'b1;
      end else begin
        if (lo_q != '1) lo_q <= lo_q + 1'b1;
      end
      if (restart)      armed_q <= 1'b0;
      else if (rise_ev) armed_q <= 1'b1;
    end
  end
endmodule

// File: rtl/sp_settle.sv
module sp_settle #(
  parameter int SETTLE = 61,
  parameter int IDLE   = 12000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_ev,
  input  logic dec_ev,
  input  logic dec_neg,
  input  logic mode_chg,
  output logic pol,
  output logic settled,
  output logic idle_hit,
  output logic restart
);
  localparam int SW = $clog2(SETTLE + 1);
  localparam int IW = $clog2(IDLE + 1);

  logic [SW-1:0] run_q;
  logic [IW-1:0] idle_q;
  logic          pol_q;

  assign idle_hit = (idle_q == IW'(IDLE - 1)) & ~rise_ev;
  assign restart  = mode_chg | idle_hit;
  assign pol      = pol_q;
  assign settled  = (run_q == SW'(SETTLE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      idle_q <= '0;
      pol_q  <= 1'b0;
    end else begin
      if (rise_ev || mode_chg)   idle_q <= '0;
      else if (idle_q != IW'(IDLE)) idle_q <= idle_q + 1'b1;

      if (restart) begin
        run_q <= '0;
      end else if (dec_ev) begin
        pol_q <= dec_neg;
        run_q <= SW'(sp_pkg::next_run(32'(run_q), SETTLE, dec_neg == pol_q));
      end
    end
  end
endmodule

// File: rtl/sp_pol_chan.sv
module sp_pol_chan #(
  parameter int STAGES = 2,
  parameter int CW     = 16,
  parameter int SETTLE = 61,
  parameter int IDLE   = 12000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_in,
  input  logic mode_chg,
  output logic sync_out,
  output logic pol,
  output logic settled,
  output logic lvl,
  output logic dec_ev,
  output logic dec_neg,
  output logic idle_hit
);
  logic rise_ev;
  logic restart;

  sp_sync #(.STAGES(STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (sync_in),
    .q     (lvl)
  );

  sp_duty_cmp #(.CW(CW)) u_duty (
    .clk     (clk),
    .rst_n   (rst_n),
    .lvl     (lvl),
    .restart (restart),
    .rise_ev (rise_ev),
    .dec_ev  (dec_ev),
    .dec_neg (dec_neg)
  );

  sp_settle #(.SETTLE(SETTLE), .IDLE(IDLE)) u_settle (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise_ev  (rise_ev),
    .dec_ev   (dec_ev),
    .dec_neg  (dec_neg),
    .mode_chg (mode_chg),
    .pol      (pol),
    .settled  (settled),
    .idle_hit (idle_hit),
    .restart  (restart)
  );

  assign sync_out = lvl ^ pol;
endmodule

// File: rtl/sync_polarity_norm.sv
module sync_polarity_norm #(
  parameter int SYNC_STAGES = 2,
  parameter int H_CNT_W     = 16,
  parameter int V_CNT_W     = 20,
  parameter int H_SETTLE    = 61,
  parameter int V_SETTLE    = 5,
  parameter int H_IDLE      = 12000,
  parameter int V_IDLE      = 3000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hsync_in,
  input  logic vsync_in,
  input  logic mode_chg,
  output logic hsync_out,
  output logic vsync_out,
  output logic h_inv,
  output logic v_inv,
  output logic h_settled,
  output logic v_settled
);
  localparam int NCH = 2;

  logic [NCH-1:0] raw_in;
  logic [NCH-1:0] chan_out;
  logic [NCH-1:0] chan_pol;
  logic [NCH-1:0] chan_set;
  logic [NCH-1:0] chan_lvl;
  logic [NCH-1:0] chan_dec_ev;
  logic [NCH-1:0] chan_dec_neg;
  logic [NCH-1:0] chan_idle_hit;

  assign raw_in = {vsync_in, hsync_in};

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    localparam int CW_G     = (g == 0) ? H_CNT_W  : V_CNT_W;
    localparam int SETTLE_G = (g == 0) ? H_SETTLE : V_SETTLE;
    localparam int IDLE_G   = (g == 0) ? H_IDLE   : V_IDLE;

    sp_pol_chan #(
      .STAGES (SYNC_STAGES),
      .CW     (CW_G),
      .SETTLE (SETTLE_G),
      .IDLE   (IDLE_G)
    ) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .sync_in  (raw_in[g]),
      .mode_chg (mode_chg),
      .sync_out (chan_out[g]),
      .pol      (chan_pol[g]),
      .settled  (chan_set[g]),
      .lvl      (chan_lvl[g]),
      .dec_ev   (chan_dec_ev[g]),
      .dec_neg  (chan_dec_neg[g]),
      .idle_hit (chan_idle_hit[g])
    );
  end

  assign hsync_out = chan_out[0];
  assign vsync_out = chan_out[1];
  assign h_inv     = chan_pol[0];
  assign v_inv     = chan_pol[1];
  assign h_settled = chan_set[0];
  assign v_settled = chan_set[1];
endmodule

// File: rtl/sp_norm_chk.sv
module sp_norm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mode_chg,
  input logic [1:0] lvl,
  input logic [1:0] out,
  input logic [1:0] pol,
  input logic [1:0] settled,
  input logic [1:0] dec_ev,
  input logic [1:0] dec_neg,
  input logic [1:0] idle_hit
);
  for (genvar g = 0; g < 2; g++) begin : g_chk
    // R1
    out_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(pol[g]) && $stable(lvl[g]) |-> $stable(out[g]));
    // R2
    pol_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_ev[g] |=> pol[g] == $past(dec_neg[g]));
    // R2
    pol_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pol[g]) |-> $past(dec_ev[g]));
    // R3
    settle_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(settled[g]) |-> $past(dec_ev[g]));
    // R5
    flip_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_ev[g] && (dec_neg[g] != pol[g]) |=> !settled[g]);
    // R6
    mode_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_chg |=> !settled[g]);
    // R7
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idle_hit[g] |=> !settled[g]);
  end
endmodule

bind sync_polarity_norm sp_norm_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode_chg (mode_chg),
  .lvl      (chan_lvl),
  .out      (chan_out),
  .pol      (chan_pol),
  .settled  (chan_set),
  .dec_ev   (chan_dec_ev),
  .dec_neg  (chan_dec_neg),
  .idle_hit (chan_idle_hit)
);

// File: tb/sim_sync_polarity_norm.sv
module sim_sync_polarity_norm;
  localparam int CLK_PERIOD = 10;
  localparam int H_IDLE     = 300;
  localparam int V_IDLE     = 1500;
  localparam int WD_LIMIT   = 150000;

  logic clk = 1'b0;
  logic rst_n, hs_in, vs_in, mode_chg;
  logic hs_out, vs_out, h_inv, v_inv, h_set, v_set;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_polarity_norm #(
    .H_CNT_W (8), .V_CNT_W (12), .H_IDLE (H_IDLE), .V_IDLE (V_IDLE)
  ) u0 (
    .clk (clk), .rst_n (rst_n), .hsync_in (hs_in), .vsync_in (vs_in),
    .mode_chg (mode_chg), .hsync_out (hs_out), .vsync_out (vs_out),
    .h_inv (h_inv), .v_inv (v_inv), .h_settled (h_set), .v_settled (v_set)
  );

  typedef struct {
    int    cyc;
    int    sig;
    bit    val;
    string req;
  } exp_t;

  exp_t  q[$];
  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  int    last_rise = 0;
  bit    done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // sig codes: 0 hs_out, 1 vs_out, 2 h_inv, 3 v_inv, 4 h_settled, 5 v_settled
  function automatic bit sample(input int s);
    case (s)
      0: return hs_out;
      1: return vs_out;
      2: return h_inv;
      3: return v_inv;
      4: return h_set;
      default: return v_set;
    endcase
  endfunction

  function automatic string sig_name(input int s);
    case (s)
      0: return "hsync_out";
      1: return "vsync_out";
      2: return "h_inv";
      3: return "v_inv";
      4: return "h_settled";
      default: return "v_settled";
    endcase
  endfunction

  function automatic void push(input int c, input int s, input bit v, input string r);
    exp_t e;
    e.cyc = c; e.sig = s; e.val = v; e.req = r;
    q.push_back(e);
  endfunction

  // Monitor: compares each due item on its cycle; also owns the watchdog.
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].cyc == cyc) begin
        checks++;
        if (sample(q[i].sig) !== q[i].val) begin
          errors++;
          $display("FAIL %s: %s at cycle %0d actual=%0b expected=%0b",
                   q[i].req, sig_name(q[i].sig), cyc, sample(q[i].sig), q[i].val);
        end
        q.delete(i);
      end else if (q[i].cyc < cyc) begin
        checks++;
        errors++;
        $display("FAIL %s: %s item for cycle %0d missed actual=none expected=%0b",
                 q[i].req, sig_name(q[i].sig), q[i].cyc, q[i].val);
        q.delete(i);
      end
    end
    if (!done && cyc >= WD_LIMIT) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=cycle %0d expected=finish", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // Driver: n periods of hi then lo clocks on channel ch (0 H, 1 V).
  // Checkpoints at rise ia and ib push flag and settled expectations.
  // The last period's corrected output is checked on every clock.
  task automatic drive(input int ch, input int hi, input int lo, input int n,
                       input bit inv, input int ia, input bit pa, input bit sa,
                       input int ib, input bit pb, input bit sb, input string req);
    for (int p = 1; p <= n; p++) begin
      for (int j = 0; j < hi + lo; j++) begin
        @(negedge clk);
        if (ch == 0) hs_in = (j < hi);
        else         vs_in = (j < hi);
        if (j == 0) begin
          last_rise = cyc;
          if (p == ia) begin
            push(cyc + 3, 2 + ch, pa, req);
            push(cyc + 3, 4 + ch, sa, req);
          end
          if (p == ib) begin
            push(cyc + 3, 2 + ch, pb, req);
            push(cyc + 3, 4 + ch, sb, req);
          end
        end
        if (p == n) push(cyc + 2, ch, (j < hi) ^ inv, "R1");
      end
    end
  endtask

  initial begin
    rst_n = 1'b0; hs_in = 1'b0; vs_in = 1'b0; mode_chg = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    for (int s = 0; s < 6; s++) push(cyc + 1, s, 1'b0, "R9");
    repeat (3) @(negedge clk);

    // R3: positive H settles on the 62nd rise, not the 61st
    drive(0, 3, 17, 62, 1'b0, 61, 1'b0, 1'b0, 62, 1'b0, 1'b1, "R3");
    // R5: flip to active-low clears settled, then settles again
    drive(0, 17, 3, 62, 1'b1, 2, 1'b1, 1'b0, 62, 1'b1, 1'b1, "R5");
    // R7: idle timeout boundary, flag kept
    push(last_rise + 2 + H_IDLE, 4, 1'b1, "R7");
    push(last_rise + 3 + H_IDLE, 4, 1'b0, "R7");
    push(last_rise + 3 + H_IDLE, 2, 1'b1, "R7");
    repeat (H_IDLE + 5) @(negedge clk);
    // R2: tie of high and low counts gives flag 0
    drive(0, 10, 10, 3, 1'b0, 2, 1'b0, 1'b0, 0, 1'b0, 1'b0, "R2");
    // R4: vertical settles after V_SETTLE decisions
    drive(1, 4, 60, 6, 1'b0, 5, 1'b0, 1'b0, 6, 1'b0, 1'b1, "R4");
    // R10: horizontal activity leaves vertical state alone
    drive(0, 17, 3, 4, 1'b1, 2, 1'b1, 1'b0, 0, 1'b0, 1'b0, "R2");
    push(cyc + 1, 3, 1'b0, "R10");
    push(cyc + 1, 5, 1'b1, "R10");
    // R5 on vertical: active-low frames
    drive(1, 60, 4, 6, 1'b1, 2, 1'b1, 1'b0, 6, 1'b1, 1'b1, "R5");
    // R8: vertical idle timeout boundary
    push(last_rise + 2 + V_IDLE, 5, 1'b1, "R8");
    push(last_rise + 3 + V_IDLE, 5, 1'b0, "R8");
    push(last_rise + 3 + V_IDLE, 3, 1'b1, "R8");
    repeat (V_IDLE + 5) @(negedge clk);
    // R6: settle, pulse mode change, then the first rise only re-arms
    drive(0, 3, 17, 62, 1'b0, 61, 1'b0, 1'b0, 62, 1'b0, 1'b1, "R3");
    @(negedge clk);
    mode_chg = 1'b1;
    push(cyc + 1, 4, 1'b0, "R6");
    push(cyc + 1, 5, 1'b0, "R6");
    @(negedge clk);
    mode_chg = 1'b0;
    drive(0, 3, 17, 62, 1'b0, 61, 1'b0, 1'b0, 62, 1'b0, 1'b1, "R6");

    while (q.size() != 0) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule